// File: doc/BRIEF.md
# Configuration Image Size Extractor

This block watches the opening bytes of a configuration image as they stream out of a serial flash and works out how many bytes the stored image occupies. Bytes reach it one per cycle with `in_valid` high, already in the bit order the header uses. After a `start` pulse the parser hunts for the sync byte, stepping over filler bytes. It then steps over a fixed-length register field and gathers a bit count, least significant byte first. The bit count is rounded up to whole bytes.

The result stays on the outputs until the next `start`. The result is either a valid size or an explicit unknown verdict with the size forced to zero. Bytes that arrive once a verdict is reached, or before the first `start`, have no effect. The search is confined to a fixed window from the first byte after `start`, so a missing or damaged header always ends in a verdict and never leaves the parser waiting.

Top module: `hdr_len_extract`

## Requirements
- R1: After reset the size output is zero and both flags are low, and bytes presented before the first `start` pulse leave all outputs unchanged.
- R2: A `start` pulse clears the size and both flags on the next clock and rearms the hunt at window position 0. A byte presented in the same cycle as `start` is dropped.
- R3: While hunting, a byte of value 0xFF is filler and is skipped. Cycles with `in_valid` low do not advance any position.
- R4: A byte of value 0x6A found while hunting marks the header. The next 4 accepted bytes are a register field whose contents are ignored, even if they equal 0x6A or 0xFF. The 4 bytes after that form a 32-bit bit count, with the first received byte in bits 7:0 and the last in bits 31:24.
- R5: The size equals (bit count + 7) >> 3, computed with a 33-bit intermediate so that no carry is lost (bit count 0xFFFFFFFF gives 0x20000000). `size_valid` rises on the clock edge that accepts the last bit-count byte.
- R6: Any byte other than 0xFF or 0x6A seen while hunting ends the search with `size_unknown` high and a size of zero, from the clock edge that accepts that byte.
- R7: The sync byte is accepted only at window positions 0 to 119 (window of 128 bytes less 9 header bytes). A sync byte at position 119 is valid. A filler byte at position 119 ends the search as unknown.
- R8: Once a verdict is reached, the size and both flags hold their values, and further bytes are ignored until the next `start`.
- R9: `size_valid` and `size_unknown` are never high together, and the size is zero whenever `size_unknown` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that clears the result and rearms the hunt |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Stream byte, already in header bit order |
| size_bytes | output | 32 | Image size in bytes, zero unless `size_valid` |
| size_valid | output | 1 | A header was parsed and `size_bytes` is meaningful |
| size_unknown | output | 1 | The search failed, and the size is reported as zero |

## Verification
The assertions assume that reset is high from time zero and that `start`, `in_valid` and `in_byte` carry known values at every rising edge. They do not assume that `start` is a single pulse or that it stays away from in-flight bytes. The stimulus changes every input only on the falling edge. It keeps `in_byte` defined even while `in_valid` is low, and it deliberately overlaps `start` with a valid byte and with a header that is only partly parsed. This shows that the hold and clear properties rely only on the order of edges.

// File: rtl/hdr_len_pkg.sv
package hdr_len_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_HUNT,
        PS_SKIP,
        PS_GATHER,
        PS_DONE
    } parse_state_t;

    typedef struct packed {
        logic found;
        logic unknown;
    } verdict_t;

    // Round a bit count up to whole bytes without losing the carry.
    function automatic logic [63:0] bits_to_bytes(input logic [63:0] bits);
        return (bits + 64'd7) >> 3;
    endfunction

endpackage

// File: rtl/hdr_pos_ctr.sv
module hdr_pos_ctr #(
    parameter int WINDOW = 128,
    localparam int POS_W = $clog2(WINDOW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [POS_W-1:0] pos
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            pos <= '0;
        else if (step)
            pos <= pos + 1'b1;
    end
endmodule

// File: rtl/hdr_le_gather.sv
module hdr_le_gather
    import hdr_len_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int ACC_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift,
    input  logic [BYTE_W-1:0] din,
    output logic [ACC_W-1:0]  acc,
    output logic [ACC_W-1:0]  acc_next
);
    // Each new byte enters at the top lane; after NBYTES shifts the
    // first byte received sits in the lowest lane.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        if (g == NBYTES - 1) begin : g_top
            assign acc_next[g*BYTE_W +: BYTE_W] = din;
        end else begin : g_mid
            assign acc_next[g*BYTE_W +: BYTE_W] = acc[(g+1)*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            acc <= '0;
        else if (shift)
            acc <= acc_next;
    end
endmodule

// File: rtl/hdr_len_extract.sv
module hdr_len_extract
    import hdr_len_pkg::*;
#(
    parameter int          WINDOW      = 128,
    parameter int          FIELD_BYTES = 4,
    parameter int          COUNT_BYTES = 4,
    parameter logic [7:0]  SYNC_BYTE   = 8'h6A,
    parameter logic [7:0]  PAD_BYTE    = 8'hFF,
    localparam int         CNT_W       = COUNT_BYTES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic [CNT_W-1:0] size_bytes,
    output logic             size_valid,
    output logic             size_unknown
);
    localparam int POS_W     = $clog2(WINDOW);
    localparam int LAST_HUNT = WINDOW - 1 - FIELD_BYTES - COUNT_BYTES;
    localparam int PH_MAX    = (FIELD_BYTES > COUNT_BYTES) ? FIELD_BYTES : COUNT_BYTES;
    localparam int PH_W      = $clog2(PH_MAX + 1);

    parse_state_t     state_q;
    logic [PH_W-1:0]  phase_q;
    logic [POS_W-1:0] pos;
    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] acc_next;
    logic [CNT_W-1:0] rounded;
    verdict_t         verdict_q;
    logic             take;

    assign take = in_valid && !start;

    hdr_pos_ctr #(.WINDOW(WINDOW)) u_pos (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .step  (take && (state_q == PS_HUNT)),
        .pos   (pos)
    );

    hdr_le_gather #(.NBYTES(COUNT_BYTES)) u_gather (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .shift    (take && (state_q == PS_GATHER)),
        .din      (in_byte),
        .acc      (acc),
        .acc_next (acc_next)
    );

    assign rounded = CNT_W'(bits_to_bytes(64'(acc_next)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PS_IDLE;
            phase_q    <= '0;
            size_bytes <= '0;
            verdict_q  <= '0;
        end else if (start) begin
            state_q    <= PS_HUNT;
            phase_q    <= '0;
            size_bytes <= '0;
            verdict_q  <= '0;
        end else if (in_valid) begin
            unique case (state_q)
                PS_HUNT: begin
                    if (in_byte == SYNC_BYTE) begin
                        state_q <= PS_SKIP;
                        phase_q <= '0;
                    end else if (in_byte != PAD_BYTE || pos == POS_W'(LAST_HUNT)) begin
                        state_q           <= PS_DONE;
                        verdict_q.unknown <= 1'b1;
                    end
                end
                PS_SKIP: begin
                    if (phase_q == PH_W'(FIELD_BYTES - 1)) begin
                        state_q <= PS_GATHER;
                        phase_q <= '0;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
                PS_GATHER: begin
                    if (phase_q == PH_W'(COUNT_BYTES - 1)) begin
                        state_q         <= PS_DONE;
                        size_bytes      <= rounded;
                        verdict_q.found <= 1'b1;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign size_valid   = verdict_q.found;
    assign size_unknown = verdict_q.unknown;

endmodule

// File: rtl/hdr_len_checker.sv
module hdr_len_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] size_bytes,
    input logic             size_valid,
    input logic             size_unknown
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(size_valid && size_unknown)); // R9

    AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (rst)
        size_unknown |-> (size_bytes == '0)); // R6

    AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((size_valid || size_unknown) && !start) |=>
            ($stable(size_bytes) && $stable(size_valid) && $stable(size_unknown))); // R8

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> (!size_valid && !size_unknown && size_bytes == '0)); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !size_valid |-> (size_bytes == '0)); // R1
endmodule

bind hdr_len_extract hdr_len_checker #(.CNT_W(COUNT_BYTES * 8)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .size_bytes   (size_bytes),
    .size_valid   (size_valid),
    .size_unknown (size_unknown)
);

// File: tb/tb_hdr_len_extract.sv
module tb_hdr_len_extract;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [31:0] size_bytes;
    logic        size_valid;
    logic        size_unknown;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk; // 250 MHz

    hdr_len_extract dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .size_bytes   (size_bytes),
        .size_valid   (size_valid),
        .size_unknown (size_unknown)
    );

    // Behavioural reference: 0 idle, 1 hunt, 2 field, 3 count, 4 done
    int     m_mode = 0;
    int     m_pos = 0;
    int     m_cnt = 0;
    longint m_bits = 0;
    longint e_size = 0;
    bit     e_val = 0;
    bit     e_unk = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; e_size = 0; e_val = 0; e_unk = 0;
        end else if (start) begin
            m_mode = 1; m_pos = 0; m_cnt = 0; m_bits = 0;
            e_size = 0; e_val = 0; e_unk = 0;
        end else if (in_valid) begin
            case (m_mode)
                1: begin
                    if (in_byte == 8'h6A) begin
                        m_mode = 2; m_cnt = 0;
                    end else if (in_byte == 8'hFF && m_pos < 119) begin
                        m_mode = 1;
                    end else begin
                        m_mode = 4; e_unk = 1;
                    end
                    m_pos++;
                end
                2: begin
                    m_cnt++;
                    if (m_cnt == 4) begin m_mode = 3; m_cnt = 0; end
                end
                3: begin
                    m_bits = m_bits | (longint'(in_byte) << (8 * m_cnt));
                    m_cnt++;
                    if (m_cnt == 4) begin
                        e_size = (m_bits + 7) / 8;
                        e_val = 1; m_mode = 4;
                    end
                end
                default: ;
            endcase
        end
    end

    // Every-cycle comparison against the reference (R9 covers consistency)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            tests++;
            if (size_bytes !== e_size[31:0] || size_valid !== e_val || size_unknown !== e_unk) begin
                fails++;
                $display("FAIL R9 cycle compare: got size=%0h v=%0b u=%0b expected size=%0h v=%0b u=%0b",
                         size_bytes, size_valid, size_unknown, e_size[31:0], e_val, e_unk);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got_sz, input logic got_v,
                       input logic got_u, input logic [31:0] exp_sz, input logic exp_v,
                       input logic exp_u);
        tests++;
        if (got_sz !== exp_sz || got_v !== exp_v || got_u !== exp_u) begin
            fails++;
            $display("FAIL %s: got size=%0h v=%0b u=%0b expected size=%0h v=%0b u=%0b",
                     tag, got_sz, got_v, got_u, exp_sz, exp_v, exp_u);
        end
    endtask

    task automatic put(input logic [7:0] b);
        in_valid = 1'b1; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0; in_byte = 8'h55;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic header(input logic [31:0] bits);
        put(8'h6A);
        put(8'h6A); put(8'hFF); put(8'h12); put(8'h00);
        put(bits[7:0]); put(bits[15:8]); put(bits[23:16]); put(bits[31:24]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset state", size_bytes, size_valid, size_unknown, 32'h0, 1'b0, 1'b0);
        header(32'h0000_0040);
        put(8'h00);
        chk("R1 idle ignores bytes", size_bytes, size_valid, size_unknown, 32'h0, 1'b0, 1'b0);

        // R3 filler and gaps, R4 field skip and byte order
        arm();
        put(8'hFF); gap(2); put(8'hFF); gap(1);
        put(8'h6A); put(8'h6A); gap(3); put(8'h01); put(8'hFF); put(8'h02);
        put(8'h10); gap(2); put(8'h00); put(8'h00);
        chk("R3 gaps do not advance", size_bytes, size_valid, size_unknown, 32'h0, 1'b0, 1'b0);
        put(8'h00);
        chk("R4 field skipped, 16 bits", size_bytes, size_valid, size_unknown, 32'd2, 1'b1, 1'b0);

        // R5 rounding
        arm(); header(32'h0403_0201);
        chk("R5 little-endian rounding", size_bytes, size_valid, size_unknown, 32'h0080_6041, 1'b1, 1'b0);
        arm(); header(32'd9);
        chk("R5 nine bits round to two", size_bytes, size_valid, size_unknown, 32'd2, 1'b1, 1'b0);
        arm(); header(32'hFFFF_FFFF);
        chk("R5 no carry loss", size_bytes, size_valid, size_unknown, 32'h2000_0000, 1'b1, 1'b0);
        arm(); header(32'd0);
        chk("R5 zero bits", size_bytes, size_valid, size_unknown, 32'd0, 1'b1, 1'b0);

        // R8 hold after result
        put(8'h6A); put(8'h00); gap(2);
        chk("R8 result held", size_bytes, size_valid, size_unknown, 32'd0, 1'b1, 1'b0);

        // R6 bad byte
        arm(); put(8'hFF); put(8'hFF); put(8'h00);
        chk("R6 bad byte unknown", size_bytes, size_valid, size_unknown, 32'h0, 1'b0, 1'b1);
        header(32'h100);
        chk("R8 unknown held", size_bytes, size_valid, size_unknown, 32'h0, 1'b0, 1'b1);

        // R7 window limits
        arm();
        for (int i = 0; i < 119; i++) put(8'hFF);
        header(32'd64);
        chk("R7 sync at last position", size_bytes, size_valid, size_unknown, 32'd8, 1'b1, 1'b0);
        arm();
        for (int i = 0; i < 119; i++) put(8'hFF);
        chk("R7 before window end", size_bytes, size_valid, size_unknown, 32'h0, 1'b0, 1'b0);
        put(8'hFF);
        chk("R7 filler at window end", size_bytes, size_valid, size_unknown, 32'h0, 1'b0, 1'b1);

        // R2 start with a byte in the same cycle drops it; mid-parse rearm
        start = 1'b1; in_valid = 1'b1; in_byte = 8'h00;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        chk("R2 start clears", size_bytes, size_valid, size_unknown, 32'h0, 1'b0, 1'b0);
        put(8'h6A); put(8'h11); put(8'h22);
        arm();
        header(32'd24);
        chk("R2 rearm mid-parse", size_bytes, size_valid, size_unknown, 32'd3, 1'b1, 1'b0);

        gap(2);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: got running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule